// File: doc/BRIEF.md
# Run-Time Accuracy-Selectable Carry-Chain Adder

This block is a combinational adder of parameterised width whose precision can be traded away bit by bit while it runs. Next to the two operands it takes a mask vector with one bit per position. A position whose mask bit is clear adds exactly, taking part in the normal ripple of carries. A position whose mask bit is set gives an approximate result: its sum bit is the OR of the two operand bits, and it neither passes on nor produces a carry. Setting a contiguous run of low mask bits makes the low part of the result approximate and leaves the upper part exact. This shortens the worst carry path and cuts switching activity, at the cost of a bounded error in the low bits.

Every bit position has a small propagate/generate cell. The cells feed a multiplexer-and-XOR carry structure, arranged in 4-bit slices in the same way as a hard carry chain in a programmable fabric. The least significant position acts as a half adder and has no carry input. A single force-exact input overrides the whole mask, so that a caller can ask for a true sum without rebuilding the mask vector.

Top module: `camask_adder`

## Requirements
- R1: With force_exact low and every mask bit 0, {cout, sum} equals the full (WIDTH+1)-bit sum a + b.
- R2: For every position i with mask[i] = 1 and force_exact low, sum[i] equals a[i] OR b[i], whatever the carry arriving from below.
- R3: A masked position passes on no carry. If mask[i] = 1 and mask[i+1] = 0, then sum[i+1] equals a[i+1] XOR b[i+1]. If mask[WIDTH-1] = 1, then cout is 0.
- R4: With the low n mask bits set to 1 and all others 0 (for 0 <= n < WIDTH), {cout, sum[WIDTH-1:n]} equals a[WIDTH-1:n] + b[WIDTH-1:n]. With n = WIDTH, sum equals a OR b and cout is 0.
- R5: For any mask pattern, including patterns that are not contiguous, the result matches a bit-serial model. That model starts with carry 0 at bit 0. A masked bit gives OR and resets the carry to 0. An unmasked bit gives a full-adder sum and carry. A carry produced below a masked bit is dropped.
- R6: With force_exact high, {cout, sum} equals a + b for every mask value.
- R7: Bit 0 has no carry input. When unmasked, sum[0] equals a[0] XOR b[0].
- R8: Carries cross the 4-bit slice boundaries without loss. For example, all ones plus one with no mask gives sum 0 and cout 1.
- R9: The same rules hold for WIDTH = 32 and WIDTH = 64. WIDTH must be a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| mask | input | WIDTH | Per-bit approximation select, 1 = approximate |
| force_exact | input | 1 | When high, the mask is ignored and the sum is exact |
| sum | output | WIDTH | Result bits |
| cout | output | 1 | Carry out of the most significant position |

## Verification
Two things happen in the same evaluation: approximate OR bits in the masked low field, and exact carry propagation in the unmasked field just above them. The boundary between the two is where a carry could wrongly leak upward. The bench provokes this by sweeping every contiguous low-mask count from 0 to WIDTH with random operands. It judges the upper field against the arithmetic sum of the operands' upper parts, and judges the whole word against a bit-serial model. A second overlap comes from a set mask together with force_exact. That case is judged against a plain a + b.

// File: rtl/camask_pkg.sv
package camask_pkg;

  // Number of bit positions grouped into one carry-chain slice.
  localparam int unsigned SLICE_W = 4;

  // Per-bit output of the lookup cell that feeds the chain.
  typedef struct packed {
    logic prop;   // mux select and XOR operand
    logic gen;    // value taken when prop is low
    logic kill;   // blocks the incoming carry
  } pg_t;

endpackage

// File: rtl/camask_pg_cell.sv
module camask_pg_cell
  import camask_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic msk_i,
  output pg_t  pg_o
);

  // Exact: prop = x ^ y, gen = x (selected only when x == y).
  // Approximate: prop = x | y so the XOR yields the OR, gen = 0, carry killed.
  always_comb begin
    pg_o.kill = msk_i;
    if (msk_i) begin
      pg_o.prop = x_i | y_i;
      pg_o.gen  = 1'b0;
    end else begin
      pg_o.prop = x_i ^ y_i;
      pg_o.gen  = x_i;
    end
  end

endmodule

// File: rtl/camask_chain_slice.sv
module camask_chain_slice
  import camask_pkg::*;
(
  input  pg_t [SLICE_W-1:0]  pg_i,
  input  logic               c_i,
  output logic [SLICE_W-1:0] s_o,
  output logic               c_o
);

  logic carry_q;
  logic carry_eff;

  // Ripple through the four mux/XOR stages of the slice.
  always_comb begin
    carry_q   = c_i;
    carry_eff = 1'b0;
    s_o       = '0;
    for (int j = 0; j < SLICE_W; j++) begin
      carry_eff = carry_q & ~pg_i[j].kill;
      s_o[j]    = pg_i[j].prop ^ carry_eff;
      carry_q   = pg_i[j].prop ? carry_eff : pg_i[j].gen;
    end
    c_o = carry_q;
  end

endmodule

// File: rtl/camask_adder.sv
module camask_adder
  import camask_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] mask,
  input  logic             force_exact,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int unsigned NUM_SLICES = WIDTH / SLICE_W;

  logic [WIDTH-1:0] mask_eff;
  pg_t  [WIDTH-1:0] pg_vec;

  assign mask_eff = force_exact ? '0 : mask;

  // One lookup cell per bit position.
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    camask_pg_cell u_cell (
      .x_i   (a[i]),
      .y_i   (b[i]),
      .msk_i (mask_eff[i]),
      .pg_o  (pg_vec[i])
    );
  end

  // Slices chained LSB to MSB; slice 0 sees a constant 0 (half-adder LSB).
  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_sl
    logic cin_w;
    logic cout_w;
    if (s == 0) begin : g_first
      assign cin_w = 1'b0;
    end else begin : g_next
      assign cin_w = g_sl[s-1].cout_w;
    end
    camask_chain_slice u_slice (
      .pg_i (pg_vec[s*SLICE_W +: SLICE_W]),
      .c_i  (cin_w),
      .s_o  (sum[s*SLICE_W +: SLICE_W]),
      .c_o  (cout_w)
    );
  end

  assign cout = g_sl[NUM_SLICES-1].cout_w;

endmodule

// File: rtl/camask_adder_chk.sv
module camask_adder_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] mask,
  input logic             force_exact,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);

  always_comb begin
    if (force_exact || (mask == '0)) begin
      AST_EXACT_SUM: assert ({cout, sum} == ({1'b0, a} + {1'b0, b})) // R1
        else $error("exact sum mismatch");
    end
    if (!force_exact && !mask[0]) begin
      AST_LSB_HALF: assert (sum[0] == (a[0] ^ b[0])) // R7
        else $error("bit 0 saw a carry-in");
    end
    if (!force_exact && mask[WIDTH-1]) begin
      AST_TOP_MASK_COUT: assert (!cout) // R3
        else $error("masked MSB produced carry");
    end
    for (int i = 0; i < WIDTH; i++) begin
      if (!force_exact && mask[i]) begin
        AST_MASKED_OR: assert (sum[i] == (a[i] | b[i])) // R2
          else $error("masked bit %0d not OR", i);
      end
      if (i < WIDTH - 1) begin
        if (!force_exact && mask[i] && !mask[i+1]) begin
          AST_CARRY_STOP: assert (sum[i+1] == (a[i+1] ^ b[i+1])) // R3
            else $error("carry leaked past masked bit %0d", i);
        end
      end
    end
  end

endmodule

bind camask_adder camask_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a           (a),
  .b           (b),
  .mask        (mask),
  .force_exact (force_exact),
  .sum         (sum),
  .cout        (cout)
);

// File: tb/tb_camask_adder.sv
module tb_camask_adder;

  logic clk;
  logic rst_n;
  int   n_vec;
  int   n_fail;
  int   cyc;

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [31:0] a32, b32, m32, s32;
  logic        fe32, c32;
  logic [63:0] a64, b64, m64, s64;
  logic        fe64, c64;

  camask_adder #(.WIDTH(32)) dut (
    .a(a32), .b(b32), .mask(m32), .force_exact(fe32), .sum(s32), .cout(c32)
  );

  camask_adder #(.WIDTH(64)) dut64 (
    .a(a64), .b(b64), .mask(m64), .force_exact(fe64), .sum(s64), .cout(c64)
  );

  // Bit-serial model of the masking rules (R5); carry lands at bit w.
  function automatic logic [64:0] ref_model(input logic [63:0] x, input logic [63:0] y,
                                            input logic [63:0] m, input bit fe, input int w);
    logic [64:0] r;
    logic c;
    r = '0;
    c = 1'b0;
    for (int i = 0; i < w; i++) begin
      if (m[i] && !fe) begin
        r[i] = x[i] | y[i];
        c    = 1'b0;
      end else begin
        r[i] = x[i] ^ y[i] ^ c;
        c    = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
      end
    end
    r[w] = c;
    return r;
  endfunction

  function automatic logic [63:0] low_mask(input int n);
    logic [63:0] one;
    one = '1;
    if (n >= 64) return one;
    return ~(one << n);
  endfunction

  task automatic check(input string tag, input logic [64:0] got, input logic [64:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply32(input logic [31:0] x, input logic [31:0] y, input logic [31:0] m, input bit fe);
    a32 = x; b32 = y; m32 = m; fe32 = fe;
    #5;
  endtask

  task automatic apply64(input logic [63:0] x, input logic [63:0] y, input logic [63:0] m, input bit fe);
    a64 = x; b64 = y; m64 = m; fe64 = fe;
    #5;
  endtask

  function automatic logic [31:0] rnd32();
    return $urandom();
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // Watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_fail = 0; cyc = 0;
    rst_n = 1'b0;
    a32 = '0; b32 = '0; m32 = '0; fe32 = 1'b0;
    a64 = '0; b64 = '0; m64 = '0; fe64 = 1'b0;
    void'($urandom(32'h1234_5678));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Initial all-zero state gives zero result (R1)
    apply32('0, '0, '0, 1'b0);
    check("R1 zero", {33'b0, c32, s32}, 65'd0);

    // R8: carry across every slice boundary
    apply32(32'hFFFF_FFFF, 32'h1, '0, 1'b0);
    check("R8 ripple32", {32'b0, c32, s32}, {32'b0, 1'b1, 32'h0});
    apply64('1, 64'h1, '0, 1'b0);
    check("R8 ripple64", {c64, s64}, {1'b1, 64'h0});
    apply32(32'h0000_000F, 32'h1, '0, 1'b0);
    check("R8 slice0to1", {32'b0, c32, s32}, {33'b0, 32'h10});

    // R7: bit 0 half adder
    apply32(32'h1, 32'h1, '0, 1'b0);
    check("R7 lsb", {32'b0, c32, s32}, {33'b0, 32'h2});

    // R3: masked MSB gives no cout
    apply32(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 1'b0);
    check("R3 msb", {32'b0, c32, s32}, {33'b0, 32'h8000_0000});
    // R3: carry generated below masked bit is dropped
    apply32(32'h0000_0003, 32'h0000_0001, 32'h0000_0002, 1'b0);
    check("R3 stop", {32'b0, c32, s32}, {33'b0, 32'h0000_0002});

    // R1: random exact sums
    for (int k = 0; k < 500; k++) begin
      logic [31:0] x, y;
      x = rnd32(); y = rnd32();
      apply32(x, y, '0, 1'b0);
      check("R1 exact32", {32'b0, c32, s32}, {32'b0, ({1'b0, x} + {1'b0, y})});
    end

    // R4 / R2: contiguous low masks for every n, 32-bit
    for (int n = 0; n <= 32; n++) begin
      for (int k = 0; k < 150; k++) begin
        logic [31:0] x, y, m;
        logic [32:0] full;
        x = rnd32(); y = rnd32();
        if (k == 0) begin x = '1; y = '1; end
        m = low_mask(n);
        apply32(x, y, m, 1'b0);
        full = {c32, s32};
        if (n < 32) begin
          check("R4 upper32", {32'b0, (full >> n)},
                {32'b0, (({1'b0, x} >> n) + ({1'b0, y} >> n))});
        end else begin
          check("R4 allmask32", {32'b0, full}, {33'b0, x | y});
        end
        check("R2 lowor32", {33'b0, (s32 & m)}, {33'b0, ((x | y) & m)});
      end
    end

    // R9: contiguous sweep on the 64-bit instance
    for (int n = 0; n <= 64; n++) begin
      for (int k = 0; k < 40; k++) begin
        logic [63:0] x, y, m;
        x = rnd64(); y = rnd64();
        m = low_mask(n);
        apply64(x, y, m, 1'b0);
        check("R9 w64", {c64, s64}, ref_model(x, y, m, 1'b0, 64));
        if (n < 64)
          check("R9 upper64", ({c64, s64} >> n),
                (({1'b0, x} >> n) + ({1'b0, y} >> n)));
      end
    end

    // R5: arbitrary masks
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] x, y, m;
      x = rnd32(); y = rnd32(); m = rnd32();
      apply32(x, y, m, 1'b0);
      check("R5 sparse32", {32'b0, c32, s32}, ref_model({32'b0, x}, {32'b0, y}, {32'b0, m}, 1'b0, 32));
    end

    // R6: force_exact overrides mask
    for (int k = 0; k < 500; k++) begin
      logic [31:0] x, y, m;
      x = rnd32(); y = rnd32(); m = rnd32();
      if (k == 0) begin x = '1; y = 32'h1; m = '1; end
      apply32(x, y, m, 1'b1);
      check("R6 force32", {32'b0, c32, s32}, {32'b0, ({1'b0, x} + {1'b0, y})});
    end
    for (int k = 0; k < 200; k++) begin
      logic [63:0] x, y;
      x = rnd64(); y = rnd64();
      apply64(x, y, '1, 1'b1);
      check("R6 force64", {c64, s64}, {1'b0, x} + {1'b0, y});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule